// File: doc/BRIEF.md
# Microcontroller Port Bit Latch Array

This block holds the output latches and input samplers for the parallel I/O ports of a small microcontroller core. It has six 8-bit ports. Ports 0 to 4 are bidirectional and each has a D-type latch per bit. Port 5 is input only and drives nothing. The core reaches the block over a simple register bus. It carries a port index, a write strobe with write data, and two separate read strobes. One read strobe returns what was last written to the latch. The other returns the synchronized level seen on the pins. The core can therefore run read-modify-write sequences on the latch while still being able to see the true pin state.

On the pad side, each bidirectional bit presents a quasi-bidirectional interface to an external pad model. While the latch holds 0, the bit drives low. While the latch holds 1, the bit releases the pin and turns on a pull-up, so the pin can serve as an input. Bits 6 and 7 of port 1 can be handed to an external two-wire serial controller. These two bits never have a pull-up. They pull low when either the latch or the serial controller's output asks for a low, and otherwise they leave the line floating. All pin levels pass through a two-stage synchronizer before they reach the read path or the serial controller.

Top module: `mcu_port_bank`

## Requirements
- R1: After reset every latch holds all ones. As a result, `pad_oe` is all zero, `pad_pu` is one on every bit except pad bits 14 and 15, and a latch read of ports 0 to 4 returns 8'hFF.
- R2: A clock edge with `wr_en` high and `addr` in 0 to 4 loads `wdata` into that port's latch. It leaves every other latch unchanged.
- R3: With `rd_latch` high, `rdata` shows the addressed latch in the same cycle. With only `rd_pin` high, `rdata` shows the addressed port's synchronized pin level. With neither strobe high, `rdata` is 0.
- R4: A change on `pin_in` reaches the pin read path, and `scl_in`/`sda_in`, after exactly two rising clock edges. It is not visible after one.
- R5: For an ordinary bidirectional pad bit k = 8*port + bit, `pad_oe[k]` is the inverse of the latch bit, `pad_out[k]` equals the latch bit, and `pad_pu[k]` equals the latch bit.
- R6: Pad bits 14 (port 1 bit 6, clock line) and 15 (port 1 bit 7, data line) are open-drain. For these bits `pad_pu` and `pad_out` are always 0. `pad_oe` is 1 exactly when the latch bit is 0, or when `od_sel` is high and the matching `scl_out`/`sda_out` is 0.
- R7: Port 5 (`addr` 5) has no driver. Writes to it change no latch and no pad output. A latch read of port 5 returns its synchronized pin level.
- R8: When both read strobes are high, the latch path wins. Addresses 6 and 7 read as 0 on both paths, and writes to them change no state.
- R9: `scl_in` and `sda_in` carry the synchronized levels of pin bits 14 and 15 at all times, whether or not `od_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Port index on the register bus |
| wr_en | input | 1 | Write strobe into the addressed latch |
| wdata | input | 8 | Write data |
| rd_latch | input | 1 | Read strobe for the latch path |
| rd_pin | input | 1 | Read strobe for the pin path |
| rdata | output | 8 | Read data |
| pin_in | input | 48 | Raw pin levels, port p bit b at index 8*p+b |
| pad_oe | output | 40 | Drive enable per bidirectional pad bit |
| pad_out | output | 40 | Drive value per bidirectional pad bit |
| pad_pu | output | 40 | Pull-up enable per bidirectional pad bit |
| od_sel | input | 1 | Hands port 1 bits 6 and 7 to the serial controller |
| scl_out | input | 1 | Serial controller clock-line output (0 pulls low) |
| sda_out | input | 1 | Serial controller data-line output (0 pulls low) |
| scl_in | output | 1 | Synchronized clock-line level |
| sda_in | output | 1 | Synchronized data-line level |

## Verification
The latch and pin read paths are driven with deliberately different contents: a latch pattern of 8'hA5 against a pin pattern of 8'h3C. A check passes only if the design picks the right source. Walking writes to every port, and writes to address 5 and address 6, show whether a write lands only in the addressed latch or leaks into other ports. A single pin toggle is sampled after one and after two edges to pin down the synchronizer depth. The open-drain bits are run through every combination of latch value, `od_sel` and serial output. This separates the wired-AND pull-down from ordinary quasi-bidirectional behaviour.

// File: rtl/mcu_port_bank.sv
module mcu_port_bank #(
  parameter int W       = 8,
  parameter int NPORTS  = 6,
  parameter int ADDR_W  = 3,
  parameter int OD_PORT = 1,
  parameter int OD_BIT  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr_en,
  input  logic [W-1:0]          wdata,
  input  logic                  rd_latch,
  input  logic                  rd_pin,
  output logic [W-1:0]          rdata,
  input  logic [NPORTS*W-1:0]   pin_in,
  output logic [(NPORTS-1)*W-1:0] pad_oe,
  output logic [(NPORTS-1)*W-1:0] pad_out,
  output logic [(NPORTS-1)*W-1:0] pad_pu,
  input  logic                  od_sel,
  input  logic                  scl_out,
  input  logic                  sda_out,
  output logic                  scl_in,
  output logic                  sda_in
);
  localparam int NDRV  = NPORTS - 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SCL_K = OD_PORT * W + OD_BIT;
  localparam int SDA_K = SCL_K + 1;

  logic [W-1:0] lat [NDRV];
  logic [NPORTS*W-1:0] sync1, sync2;
  logic [W-1:0] lat_view [DEPTH];
  logic [W-1:0] pin_view [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NDRV; p++) lat[p] <= '1;
    end else if (wr_en) begin
      for (int p = 0; p < NDRV; p++)
        if (addr == ADDR_W'(p)) lat[p] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_comb begin
    for (int a = 0; a < DEPTH; a++) begin
      lat_view[a] = '0;
      pin_view[a] = '0;
      if (a < NPORTS) pin_view[a] = sync2[a*W +: W];
      if (a < NDRV) lat_view[a] = lat[a];
      else if (a < NPORTS) lat_view[a] = sync2[a*W +: W];
    end
  end

  assign rdata = rd_latch ? lat_view[addr] : (rd_pin ? pin_view[addr] : '0);

  genvar gp, gb;
  generate
    for (gp = 0; gp < NDRV; gp++) begin : g_port
      for (gb = 0; gb < W; gb++) begin : g_bit
        localparam int K = gp * W + gb;
        if (K == SCL_K || K == SDA_K) begin : g_od
          logic alt_o;
          assign alt_o      = (K == SCL_K) ? scl_out : sda_out;
          assign pad_oe[K]  = ~(lat[gp][gb] & (od_sel ? alt_o : 1'b1));
          assign pad_out[K] = 1'b0;
          assign pad_pu[K]  = 1'b0;
        end else begin : g_qb
          assign pad_oe[K]  = ~lat[gp][gb];
          assign pad_out[K] = lat[gp][gb];
          assign pad_pu[K]  = lat[gp][gb];
        end
      end
    end
  endgenerate

  assign scl_in = sync2[SCL_K];
  assign sda_in = sync2[SDA_K];

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_latch == 1'b0 && addr < ADDR_W'(NDRV)) |=>
      (rd_latch && addr == $past(addr)) -> (rdata == $past(wdata)));

  assert_no_drive_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= ADDR_W'(NDRV)) |=> $stable(pad_oe) && $stable(pad_pu));

  assert_sync_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (scl_in == $past(pin_in[SCL_K], 2) && sda_in == $past(pin_in[SDA_K], 2)));

  assert_od_pull_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (od_sel && (!scl_out)) |-> pad_oe[SCL_K]);

  assert_od_no_pu_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu[SCL_K] == 1'b0) && (pad_pu[SDA_K] == 1'b0) && (pad_out[SDA_K] == 1'b0));
endmodule

// File: tb/mcu_port_bank_tb.sv
module mcu_port_bank_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr_en = 0, rd_latch = 0, rd_pin = 0;
  logic [7:0] wdata = 0, rdata;
  logic [47:0] pin_in = '1;
  logic [39:0] pad_oe, pad_out, pad_pu;
  logic od_sel = 0, scl_out = 1, sda_out = 1, scl_in, sda_in;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mcu_port_bank u_dut (.clk, .rst_n, .addr, .wr_en, .wdata, .rd_latch, .rd_pin, .rdata,
    .pin_in, .pad_oe, .pad_out, .pad_pu, .od_sel, .scl_out, .sda_out, .scl_in, .sda_in);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input bit lat, input bit pin, output logic [7:0] v);
    @(negedge clk); addr = a; rd_latch = lat; rd_pin = pin;
    #1 v = rdata;
    rd_latch = 0; rd_pin = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 oe", 64'(pad_oe), 64'h0);
    chk("R1 pu", 64'(pad_pu), 64'hFF_FFFF_3FFF);
    for (int p = 0; p < 5; p++) begin rd(3'(p), 1, 0, v); chk("R1 latch", 64'(v), 64'hFF); end
  endtask

  task automatic t_write;
    logic [7:0] v;
    for (int p = 0; p < 5; p++) wr(3'(p), 8'(8'h10 + p));
    for (int p = 0; p < 5; p++) begin rd(3'(p), 1, 0, v); chk("R2 walk", 64'(v), 64'(8'h10 + p)); end
    wr(3'd2, 8'hA5);
    chk("R5 oe", 64'(pad_oe[23:16]), 64'h5A);
    chk("R5 out", 64'(pad_out[23:16]), 64'hA5);
    chk("R5 pu", 64'(pad_pu[23:16]), 64'hA5);
    rd(3'd3, 1, 0, v); chk("R2 neighbour", 64'(v), 64'h13);
  endtask

  task automatic t_paths;
    logic [7:0] v;
    @(negedge clk); pin_in[23:16] = 8'h3C;
    @(negedge clk); @(negedge clk);
    rd(3'd2, 1, 0, v); chk("R3 latch path", 64'(v), 64'hA5);
    rd(3'd2, 0, 1, v); chk("R3 pin path", 64'(v), 64'h3C);
    rd(3'd2, 0, 0, v); chk("R3 idle", 64'(v), 64'h0);
    rd(3'd2, 1, 1, v); chk("R8 priority", 64'(v), 64'hA5);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    @(negedge clk); pin_in[7:0] = 8'h00;
    @(negedge clk); addr = 0; rd_pin = 1; #1 chk("R4 one edge", 64'(rdata), 64'hFF);
    @(negedge clk); #1 chk("R4 two edges", 64'(rdata), 64'h00);
    rd_pin = 0;
  endtask

  task automatic t_port5;
    logic [7:0] v;
    logic [39:0] oe0;
    @(negedge clk); pin_in[47:40] = 8'h96;
    @(negedge clk); @(negedge clk);
    oe0 = pad_oe;
    wr(3'd5, 8'h00);
    chk("R7 no drive", 64'(pad_oe), 64'(oe0));
    rd(3'd5, 1, 0, v); chk("R7 latch reads pin", 64'(v), 64'h96);
    wr(3'd6, 8'h00);
    for (int p = 0; p < 5; p++) begin rd(3'(p), 1, 0, v); chk("R8 addr6 write", 64'(v), 64'(p == 2 ? 8'hA5 : 8'h10 + p)); end
    rd(3'd6, 1, 0, v); chk("R8 addr6 read latch", 64'(v), 64'h0);
    rd(3'd7, 0, 1, v); chk("R8 addr7 read pin", 64'(v), 64'h0);
  endtask

  task automatic t_od;
    wr(3'd1, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); od_sel = i[0]; scl_out = i[1]; sda_out = i[2];
      #1;
      chk("R6 scl oe", 64'(pad_oe[14]), 64'(od_sel && !scl_out));
      chk("R6 sda oe", 64'(pad_oe[15]), 64'(od_sel && !sda_out));
      chk("R6 pu/out", 64'({pad_pu[15:14], pad_out[15:14]}), 64'h0);
    end
    wr(3'd1, 8'h3F);
    @(negedge clk); od_sel = 1; scl_out = 1; sda_out = 1; #1;
    chk("R6 latch low", 64'(pad_oe[15:14]), 64'h3);
    @(negedge clk); pin_in[15:14] = 2'b01; od_sel = 0;
    @(negedge clk); @(negedge clk);
    chk("R9 scl", 64'(scl_in), 64'h1);
    chk("R9 sda", 64'(sda_in), 64'h0);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_write; t_paths; t_sync; t_port5; t_od;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule